// File: doc/BRIEF.md
# Rotating Operand Stack Controller

This block keeps the operand stack of a stack-oriented arithmetic coprocessor. The storage is one circular ring of bytes that can be read as eight 16-bit entries or as four 32-bit entries. A byte pointer marks the top of stack. A 32-bit command moves the pointer by four bytes and a 16-bit command moves it by two. Removing an entry destroys nothing: the ring turns, and the old top reappears at the bottom.

Commands arrive as one byte. Bit 7 asks for a service request, and the lower seven bits select push, pop, exchange or no-operation. The arithmetic datapath reads the top and next entries straight from the ports. The block keeps sign and zero status for the new top. After each accepted command it stays busy for that command's fixed cycle count. It ignores any command offered while busy, and any command whose code it does not recognise.

Port views: `top_word` holds the 32-bit top. Its low half is the 16-bit top and its high half is the 16-bit next entry. `next_word` holds the 32-bit next entry.

Top module: `operand_ring_stack`

## Requirements
- R1: After reset the whole ring is zero, the pointer is at byte 0, and busy, svc_req, sign_flag and zero_flag are all 0.
- R2: The command code is cmd_byte[6:0]. The accepted codes are: 7'h00 no-op, 7'h77 push16, 7'h37 and 7'h17 push32, 7'h78 pop16, 7'h3F and 7'h1F pop32, 7'h79 exchange16, 7'h39 and 7'h19 exchange32. cmd_byte[7] never changes the operation. svc_req takes the cmd_byte[7] of every accepted command and holds it until the next accepted command.
- R3: A push32 moves the pointer down by 4. push_data becomes top_word, the old top becomes next_word, and the oldest of the four 32-bit entries is overwritten.
- R4: A push16 moves the pointer down by 2 and writes push_data[15:0] as the new 16-bit top. The old 16-bit top appears in top_word[31:16].
- R5: Both pop32 codes do the same thing. They move the pointer up by 4, so the old next_word becomes top_word and the old top rotates to the bottom. Four pop32 commands restore the original view.
- R6: A pop16 moves the pointer up by 2 and changes no value. Eight pop16 commands restore the original view.
- R7: An exchange swaps the top and next entries at its width and leaves the pointer unchanged.
- R8: After a push, pop or exchange, sign_flag equals the MSB of the new top at the command's width: bit 31 of top_word, or bit 15 for 16-bit commands. zero_flag is 1 exactly when every bit of the new top at that width is 0.
- R9: A no-op changes nothing on the stack and clears sign_flag and zero_flag.
- R10: busy rises on the clock edge that accepts a command and stays high for exactly N cycles. N is 4 for no-op, 10 for pop16, 12 for pop32, 16 for push16, 20 for push32, 18 for exchange16 and 26 for exchange32.
- R11: A command offered while busy is high is ignored. It changes neither the stack, the flags, svc_req nor the remaining busy time.
- R12: A command with an unrecognised code is ignored. busy stays low and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command byte is offered this cycle |
| cmd_byte | input | 8 | Bit 7 service-request enable, bits 6:0 operation code |
| push_data | input | 32 | Value written by a push (low 16 bits for push16) |
| busy | output | 1 | A command is executing |
| svc_req | output | 1 | Service-request enable of the last accepted command |
| top_word | output | 32 | 32-bit top of stack; [15:0] 16-bit top, [31:16] 16-bit next |
| next_word | output | 32 | 32-bit next on stack |
| sign_flag | output | 1 | Sign of the new top at the command's width |
| zero_flag | output | 1 | New top is all zero at the command's width |

## Verification
A wrong pointer or a misplaced byte write shows on top_word and next_word on the first edge after acceptance. That is well before busy falls, so each command is judged against a byte-level model of the ring. Loss or corruption of buried entries shows only when pops rotate them back up. For this reason the tests include full rotations at both widths and deep push runs that overwrite the bottom. A busy counter that is off by one cycle, or that lets a second command in early, changes the measured busy length or moves the stack during the hold window on the very next edge.

// File: rtl/opstack_pkg.sv
`timescale 1ns/1ps
package opstack_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_XCH  = 2'd3
  } stk_op_e;

  typedef struct packed {
    logic    legal;
    logic    wide;
    stk_op_e op;
  } stk_cmd_t;

  localparam logic [6:0] CODE_NOP        = 7'h00;
  localparam logic [6:0] CODE_PUSH_HALF  = 7'h77;
  localparam logic [6:0] CODE_PUSH_WORDI = 7'h37;
  localparam logic [6:0] CODE_PUSH_WORDF = 7'h17;
  localparam logic [6:0] CODE_POP_HALF   = 7'h78;
  localparam logic [6:0] CODE_POP_WORDI  = 7'h3F;
  localparam logic [6:0] CODE_POP_WORDF  = 7'h1F;
  localparam logic [6:0] CODE_XCH_HALF   = 7'h79;
  localparam logic [6:0] CODE_XCH_WORDI  = 7'h39;
  localparam logic [6:0] CODE_XCH_WORDF  = 7'h19;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic stk_cmd_t decode_cmd(input logic [6:0] code);
    stk_cmd_t c;
    c.legal = 1'b1;
    c.wide  = 1'b1;
    c.op    = OP_NOP;
    case (code)
      CODE_NOP:        c.wide = 1'b0;
      CODE_PUSH_HALF:  begin c.op = OP_PUSH; c.wide = 1'b0; end
      CODE_PUSH_WORDI,
      CODE_PUSH_WORDF: c.op = OP_PUSH;
      CODE_POP_HALF:   begin c.op = OP_POP; c.wide = 1'b0; end
      CODE_POP_WORDI,
      CODE_POP_WORDF:  c.op = OP_POP;
      CODE_XCH_HALF:   begin c.op = OP_XCH; c.wide = 1'b0; end
      CODE_XCH_WORDI,
      CODE_XCH_WORDF:  c.op = OP_XCH;
      default:         c.legal = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/opstack_decode.sv
`timescale 1ns/1ps
module opstack_decode
  import opstack_pkg::*;
#(
  parameter int CNT_W          = 5,
  parameter int CYC_NOP        = 4,
  parameter int CYC_POP_HALF   = 10,
  parameter int CYC_POP_WORD   = 12,
  parameter int CYC_PUSH_HALF  = 16,
  parameter int CYC_PUSH_WORD  = 20,
  parameter int CYC_XCH_HALF   = 18,
  parameter int CYC_XCH_WORD   = 26
) (
  input  logic [6:0]       code,
  output stk_cmd_t         cmd,
  output logic [CNT_W-1:0] cycles
);

  always_comb begin
    cmd = decode_cmd(code);
    unique case (cmd.op)
      OP_PUSH: cycles = cmd.wide ? CNT_W'(CYC_PUSH_WORD) : CNT_W'(CYC_PUSH_HALF);
      OP_POP:  cycles = cmd.wide ? CNT_W'(CYC_POP_WORD)  : CNT_W'(CYC_POP_HALF);
      OP_XCH:  cycles = cmd.wide ? CNT_W'(CYC_XCH_WORD)  : CNT_W'(CYC_XCH_HALF);
      default: cycles = CNT_W'(CYC_NOP);
    endcase
  end

endmodule

// File: rtl/opstack_timer.sv
`timescale 1ns/1ps
module opstack_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = start | busy;

  always_comb begin
    if (start) cnt_d = load_val;
    else       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/opstack_ring.sv
`timescale 1ns/1ps
module opstack_ring
  import opstack_pkg::*;
#(
  parameter int RING_BYTES = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    apply,
  input  stk_op_e                 op,
  input  logic                    wide,
  input  logic [8*WORD_BYTES-1:0] push_data,
  output logic [8*WORD_BYTES-1:0] top_word,
  output logic [8*WORD_BYTES-1:0] next_word
);

  localparam int PTR_W      = $clog2(RING_BYTES);
  localparam int HALF_BYTES = WORD_BYTES / 2;

  logic [7:0]       mem_q [RING_BYTES];
  logic [7:0]       mem_d [RING_BYTES];
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] off [RING_BYTES];
  logic [PTR_W-1:0] step;

  assign step = wide ? PTR_W'(WORD_BYTES) : PTR_W'(HALF_BYTES);

  // distance of each byte above the current top pointer, modulo the ring
  for (genvar j = 0; j < RING_BYTES; j++) begin : g_off
    assign off[j] = PTR_W'(j) - ptr_q;
  end

  always_comb begin
    ptr_d = ptr_q;
    for (int j = 0; j < RING_BYTES; j++) mem_d[j] = mem_q[j];
    if (apply) begin
      unique case (op)
        OP_PUSH: begin
          ptr_d = ptr_q - step;
          for (int j = 0; j < RING_BYTES; j++) begin
            if (int'(off[j]) >= RING_BYTES - int'(step))
              mem_d[j] = push_data[8*(int'(off[j]) - RING_BYTES + int'(step)) +: 8];
          end
        end
        OP_POP: ptr_d = ptr_q + step;
        OP_XCH: begin
          for (int j = 0; j < RING_BYTES; j++) begin
            if (int'(off[j]) < int'(step))
              mem_d[j] = mem_q[PTR_W'(j) + step];
            else if (int'(off[j]) < 2 * int'(step))
              mem_d[j] = mem_q[PTR_W'(j) - step];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int j = 0; j < RING_BYTES; j++) mem_q[j] <= '0;
    end else if (apply) begin
      ptr_q <= ptr_d;
      for (int j = 0; j < RING_BYTES; j++) mem_q[j] <= mem_d[j];
    end
  end

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_rd
    assign top_word[8*i +: 8]  = mem_q[ptr_q + PTR_W'(i)];
    assign next_word[8*i +: 8] = mem_q[ptr_q + PTR_W'(i + WORD_BYTES)];
  end

endmodule

// File: rtl/opstack_status.sv
`timescale 1ns/1ps
module opstack_status
  import opstack_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  stk_op_e           op,
  input  logic              wide,
  input  logic              sr_bit,
  input  logic [WORD_W-1:0] new_top,
  output logic              sign_flag,
  output logic              zero_flag,
  output logic              svc_req
);

  localparam int HALF_W = WORD_W / 2;

  logic sign_d, zero_d;

  always_comb begin
    if (op == OP_NOP) begin
      sign_d = 1'b0;
      zero_d = 1'b0;
    end else if (wide) begin
      sign_d = new_top[WORD_W-1];
      zero_d = (new_top == '0);
    end else begin
      sign_d = new_top[HALF_W-1];
      zero_d = (new_top[HALF_W-1:0] == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_flag <= 1'b0;
      zero_flag <= 1'b0;
      svc_req   <= 1'b0;
    end else if (apply) begin
      sign_flag <= sign_d;
      zero_flag <= zero_d;
      svc_req   <= sr_bit;
    end
  end

endmodule

// File: rtl/operand_ring_stack.sv
`timescale 1ns/1ps
module operand_ring_stack
  import opstack_pkg::*;
#(
  parameter int RING_BYTES    = 16,
  parameter int WORD_BYTES    = 4,
  parameter int CYC_NOP       = 4,
  parameter int CYC_POP_HALF  = 10,
  parameter int CYC_POP_WORD  = 12,
  parameter int CYC_PUSH_HALF = 16,
  parameter int CYC_PUSH_WORD = 20,
  parameter int CYC_XCH_HALF  = 18,
  parameter int CYC_XCH_WORD  = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [7:0]              cmd_byte,
  input  logic [8*WORD_BYTES-1:0] push_data,
  output logic                    busy,
  output logic                    svc_req,
  output logic [8*WORD_BYTES-1:0] top_word,
  output logic [8*WORD_BYTES-1:0] next_word,
  output logic                    sign_flag,
  output logic                    zero_flag
);

  localparam int WORD_W  = 8 * WORD_BYTES;
  localparam int HALF_W  = WORD_W / 2;
  localparam int MAX_CYC = max_int(max_int(max_int(CYC_NOP, CYC_POP_HALF),
                                           max_int(CYC_POP_WORD, CYC_PUSH_HALF)),
                                   max_int(max_int(CYC_PUSH_WORD, CYC_XCH_HALF), CYC_XCH_WORD));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  stk_cmd_t          cmd;
  logic [CNT_W-1:0]  cycles;
  logic              accept;
  logic [WORD_W-1:0] new_top;

  opstack_decode #(
    .CNT_W(CNT_W), .CYC_NOP(CYC_NOP),
    .CYC_POP_HALF(CYC_POP_HALF), .CYC_POP_WORD(CYC_POP_WORD),
    .CYC_PUSH_HALF(CYC_PUSH_HALF), .CYC_PUSH_WORD(CYC_PUSH_WORD),
    .CYC_XCH_HALF(CYC_XCH_HALF), .CYC_XCH_WORD(CYC_XCH_WORD)
  ) u_decode (
    .code   (cmd_byte[6:0]),
    .cmd    (cmd),
    .cycles (cycles)
  );

  assign accept = cmd_valid & ~busy & cmd.legal;

  opstack_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .load_val (cycles),
    .busy     (busy)
  );

  opstack_ring #(.RING_BYTES(RING_BYTES), .WORD_BYTES(WORD_BYTES)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .apply     (accept),
    .op        (cmd.op),
    .wide      (cmd.wide),
    .push_data (push_data),
    .top_word  (top_word),
    .next_word (next_word)
  );

  // value that will sit on top after the command, for the status bits
  always_comb begin
    if (cmd.op == OP_PUSH)
      new_top = cmd.wide ? push_data : {{HALF_W{1'b0}}, push_data[HALF_W-1:0]};
    else
      new_top = cmd.wide ? next_word : {{HALF_W{1'b0}}, top_word[WORD_W-1:HALF_W]};
  end

  opstack_status #(.WORD_W(WORD_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .apply     (accept),
    .op        (cmd.op),
    .wide      (cmd.wide),
    .sr_bit    (cmd_byte[7]),
    .new_top   (new_top),
    .sign_flag (sign_flag),
    .zero_flag (zero_flag),
    .svc_req   (svc_req)
  );

endmodule

// File: rtl/opstack_checker.sv
`timescale 1ns/1ps
module opstack_checker
  import opstack_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_byte,
  input logic [WORD_W-1:0] push_data,
  input logic              busy,
  input logic              svc_req,
  input logic [WORD_W-1:0] top_word,
  input logic [WORD_W-1:0] next_word,
  input logic              sign_flag,
  input logic              zero_flag
);

  localparam int HALF_W = WORD_W / 2;

  stk_cmd_t c;
  logic     acc;
  assign c   = decode_cmd(cmd_byte[6:0]);
  assign acc = cmd_valid && !busy && c.legal;

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  a_r11_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(top_word) && $stable(next_word) && $stable(sign_flag)
             && $stable(zero_flag) && $stable(svc_req));

  a_r12_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !c.legal) |=> !busy && $stable(top_word)
             && $stable(next_word) && $stable(svc_req));

  a_r2_svc_tracks_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> svc_req == $past(cmd_byte[7]));

  a_r3_push_word: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && c.op == OP_PUSH && c.wide) |=>
      top_word == $past(push_data) && next_word == $past(top_word));

  a_r5_pop_word_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && c.op == OP_POP && c.wide) |=> top_word == $past(next_word));

  a_r7_exchange_word: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && c.op == OP_XCH && c.wide) |=>
      top_word == $past(next_word) && next_word == $past(top_word));

  a_r9_nop_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && c.op == OP_NOP) |=> !sign_flag && !zero_flag
      && $stable(top_word) && $stable(next_word));

  a_r8_flags_word: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && c.op != OP_NOP && c.wide) |=>
      zero_flag == (top_word == '0) && sign_flag == top_word[WORD_W-1]);

  a_r8_flags_half: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && c.op != OP_NOP && !c.wide) |=>
      zero_flag == (top_word[HALF_W-1:0] == '0) && sign_flag == top_word[HALF_W-1]);

endmodule

bind operand_ring_stack opstack_checker #(.WORD_W(8*WORD_BYTES)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .push_data (push_data),
  .busy      (busy),
  .svc_req   (svc_req),
  .top_word  (top_word),
  .next_word (next_word),
  .sign_flag (sign_flag),
  .zero_flag (zero_flag)
);

// File: tb/operand_ring_stack_test.sv
`timescale 1ns/1ps
module operand_ring_stack_test;

  localparam int RB = 16;
  localparam int WB = 4;
  localparam int W  = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [7:0]   cmd_byte = 8'h00;
  logic [W-1:0] push_data = '0;
  wire          busy, svc_req, sign_flag, zero_flag;
  wire  [W-1:0] top_word, next_word;

  int checks = 0;
  int errors = 0;

  logic [7:0] mb [RB];
  int         mp;
  logic       msign, mzero, msvc;

  operand_ring_stack uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .push_data(push_data), .busy(busy), .svc_req(svc_req), .top_word(top_word),
    .next_word(next_word), .sign_flag(sign_flag), .zero_flag(zero_flag)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] m_word(input int base);
    logic [W-1:0] r;
    for (int i = 0; i < WB; i++) r[8*i +: 8] = mb[(mp + base + i) % RB];
    return r;
  endfunction

  // kind: 0 nop, 1 push, 2 pop, 3 exchange, -1 unrecognised
  function automatic void classify(input logic [6:0] code, output int kind,
                                   output bit wide, output int cyc, output string req);
    wide = 1'b1;
    case (code)
      7'h00:        begin kind = 0; wide = 1'b0; cyc = 4;  req = "R9"; end
      7'h77:        begin kind = 1; wide = 1'b0; cyc = 16; req = "R4"; end
      7'h37, 7'h17: begin kind = 1; cyc = 20; req = "R3"; end
      7'h78:        begin kind = 2; wide = 1'b0; cyc = 10; req = "R6"; end
      7'h3F, 7'h1F: begin kind = 2; cyc = 12; req = "R5"; end
      7'h79:        begin kind = 3; wide = 1'b0; cyc = 18; req = "R7"; end
      7'h39, 7'h19: begin kind = 3; cyc = 26; req = "R7"; end
      default:      begin kind = -1; cyc = 0; req = "R12"; end
    endcase
  endfunction

  task automatic model(input logic [7:0] c, input logic [W-1:0] d,
                       output int cyc, output string req);
    int kind; bit wide; int stp; logic [W-1:0] v; logic [7:0] t;
    classify(c[6:0], kind, wide, cyc, req);
    stp = wide ? WB : WB / 2;
    case (kind)
      1: begin
        mp = (mp - stp + RB) % RB;
        for (int i = 0; i < stp; i++) mb[(mp + i) % RB] = d[8*i +: 8];
      end
      2: mp = (mp + stp) % RB;
      3: for (int i = 0; i < stp; i++) begin
        t = mb[(mp + i) % RB];
        mb[(mp + i) % RB] = mb[(mp + stp + i) % RB];
        mb[(mp + stp + i) % RB] = t;
      end
      default: ;
    endcase
    if (kind == 0) begin
      msign = 1'b0; mzero = 1'b0;
    end else if (kind > 0) begin
      v = m_word(0);
      msign = wide ? v[W-1] : v[15];
      mzero = wide ? (v == '0) : (v[15:0] == '0);
    end
    if (kind >= 0) msvc = c[7];
  endtask

  task automatic check_state(input string req);
    check(req, "top_word", top_word, m_word(0));
    check(req, "next_word", next_word, m_word(WB));
    check("R8", "sign_flag", W'(sign_flag), W'(msign));
    check("R8", "zero_flag", W'(zero_flag), W'(mzero));
    check("R2", "svc_req", W'(svc_req), W'(msvc));
  endtask

  // issue one command; optionally offer a second command while busy (R11)
  task automatic run(input logic [7:0] c, input logic [W-1:0] d, input bit interfere);
    int cyc; int n; string req;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = c; push_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    model(c, d, cyc, req);
    n = 0;
    while (busy) begin
      n++;
      if (interfere && n == 2) begin
        cmd_valid = 1'b1; cmd_byte = 8'h37; push_data = 32'hDEAD_BEEF;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(interfere ? "R11" : "R10", "busy cycles", W'(n), W'(cyc));
    check_state(req);
  endtask

  function automatic logic [7:0] pick_cmd(input int k, input bit sr);
    logic [6:0] code;
    case (k)
      0: code = 7'h00; 1: code = 7'h77; 2: code = 7'h37; 3: code = 7'h17;
      4: code = 7'h78; 5: code = 7'h3F; 6: code = 7'h1F; 7: code = 7'h79;
      8: code = 7'h39; default: code = 7'h19;
    endcase
    return {sr, code};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] saved_top, saved_next;
    void'($urandom(32'd4711));
    for (int j = 0; j < RB; j++) mb[j] = 8'h00;
    mp = 0; msign = 1'b0; mzero = 1'b0; msvc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "busy", W'(busy), '0);
    check_state("R1");

    // R3: five word pushes, the first is overwritten at the bottom
    run(8'hB7, 32'h1111_1111, 1'b0);
    run(8'h37, 32'h2222_2222, 1'b0);
    run(8'h17, 32'h8333_3333, 1'b0);
    run(8'h97, 32'h0000_0000, 1'b0);
    run(8'h37, 32'h5555_5555, 1'b0);

    // R5: four word pops restore the view, both codes alike
    saved_top = top_word; saved_next = next_word;
    run(8'h3F, '0, 1'b0);
    run(8'h1F, '0, 1'b0);
    run(8'hBF, '0, 1'b0);
    run(8'h9F, '0, 1'b0);
    check("R5", "top after full rotation", top_word, saved_top);
    check("R5", "next after full rotation", next_word, saved_next);

    // R6: eight half pops restore the view
    for (int i = 0; i < 8; i++) run(8'h78, '0, 1'b0);
    check("R6", "top after full rotation", top_word, saved_top);
    check("R6", "next after full rotation", next_word, saved_next);

    // R4: half pushes, sign and zero at half width
    run(8'hF7, 32'hFFFF_8000, 1'b0);
    run(8'h77, 32'h1234_0000, 1'b0);

    // R7: exchanges at both widths
    run(8'h79, '0, 1'b0);
    run(8'h39, '0, 1'b0);
    run(8'h99, '0, 1'b0);

    // R9 and R2: no-op with both service-request values
    run(8'h80, '0, 1'b0);
    run(8'h00, '0, 1'b0);

    // R11: command offered while busy is ignored
    run(8'h78, '0, 1'b1);
    run(8'h37, 32'hA5A5_0001, 1'b1);

    // R12: unrecognised codes
    run(8'h85, 32'hFFFF_FFFF, 1'b0);
    run(8'h7F, 32'hFFFF_FFFF, 1'b0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] d;
      d = ($urandom % 4 == 0) ? '0 : W'($urandom);
      run(pick_cmd(int'($urandom % 10), 1'($urandom)), d, ($urandom % 8) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule